// File: doc/BRIEF.md
# Dual-Path Configuration Register Arbiter

This block holds a bank of 32-bit configuration registers that two requesters share. The primary port carries configuration reads and writes that upstream logic has already decoded from link packets. A primary access runs in the cycle it is presented and is never stalled. The secondary port is a local management port for application logic. It has a read strobe, a write strobe, a byte address, write data, read data and a completion acknowledge.

A local request is first captured into a single holding slot. It runs only in a cycle with no primary request. The bank has one access path, so the two ports never update the same storage in the same cycle. Both ports go through the same per-word write masks, so a read-only bit cannot be changed from either side.

Every word has a reset value and a write mask, both derived from parameters. The low words form a fully read-only header. Above the header, even and odd words take different writable-bit patterns. Addresses beyond the implemented window still complete normally: they return zero and change nothing.

Top module: `cfgarb_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `loc_ack` and `pri_rvalid` are 0, nothing is held, and word i reads as `RST_BASE ^ i`.
- R2: Both ports select a word with address bits [8:2]; address bits [1:0] are ignored.
- R3: An address with any of bits [11:9] set is out of range. It reads as zero, a write to it changes no word, and a local access to it is still acknowledged.
- R4: Each write, from either port, stores `(old & ~mask) | (wdata & mask)`. The mask is 0 for words below `RO_WORDS` (default 4), `EVEN_MASK` (default 32'hFFFF_00FF) for the other even words, and `ODD_MASK` (default 32'h0F0F_FFFF) for the other odd words.
- R5: A local request is captured at the edge where it is seen. It executes at the first later edge at which `pri_req` is low, and never at an edge where `pri_req` is high. With `pri_req` high for k cycles starting with the strobe cycle, `loc_ack` is seen max(k,1)+1 cycles after the strobe cycle.
- R6: `loc_ack` is a one-cycle pulse. `loc_rdata` is valid in the same cycle and holds the addressed word as it was just before the local access executed.
- R7: Only one local request is held at a time. Strobes that arrive while a request is held, up to and including the edge at which it executes, are dropped.
- R8: If `loc_rden` and `loc_wren` are high together, the request is a write. A local write returns `loc_rdata` = 0 with its acknowledge.
- R9: A primary read returns `pri_rdata` with `pri_rvalid` high in the cycle after `pri_req`; `pri_rvalid` is low after a cycle without a primary read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pri_req | input | 1 | Primary configuration access this cycle |
| pri_we | input | 1 | Primary access is a write |
| pri_addr | input | 12 | Primary byte address |
| pri_wdata | input | 32 | Primary write data |
| pri_rvalid | output | 1 | Primary read data valid |
| pri_rdata | output | 32 | Primary read data |
| loc_rden | input | 1 | Local read strobe |
| loc_wren | input | 1 | Local write strobe |
| loc_addr | input | 12 | Local byte address |
| loc_wdata | input | 32 | Local write data |
| loc_rdata | output | 32 | Local read data, valid with `loc_ack` |
| loc_ack | output | 1 | Local access completed |

## Verification
A captured junk strobe would show up as an extra acknowledge, or as a later read that disagrees with the reference model. In either case it becomes visible within a few cycles of the held request completing. A wrong mask or a lost write shows up on the next read of that word from either port. Bad arbitration shows up as an acknowledge whose latency differs from max(k,1)+1, so it is caught on that same request.

// File: rtl/cfgarb_pkg.sv
package cfgarb_pkg;

  localparam int CFG_ADDR_W = 12;
  localparam int CFG_DATA_W = 32;

  typedef enum logic [1:0] {
    LOP_IDLE  = 2'd0,
    LOP_READ  = 2'd1,
    LOP_WRITE = 2'd2
  } lop_e;

endpackage

// File: rtl/cfgarb_hold.sv
module cfgarb_hold
  import cfgarb_pkg::*;
#(
  parameter int ADDR_W = CFG_ADDR_W,
  parameter int DATA_W = CFG_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              done,
  output logic              held_vld,
  output lop_e              held_op,
  output logic [ADDR_W-1:0] held_addr,
  output logic [DATA_W-1:0] held_wdata
);

  // One slot; new strobes are only looked at while the slot is empty.
  always_ff @(posedge clk) begin
    if (rst) begin
      held_vld   <= 1'b0;
      held_op    <= LOP_IDLE;
      held_addr  <= '0;
      held_wdata <= '0;
    end else if (held_vld) begin
      if (done) begin
        held_vld <= 1'b0;
        held_op  <= LOP_IDLE;
      end
    end else if (rd_stb || wr_stb) begin
      held_vld   <= 1'b1;
      held_op    <= wr_stb ? LOP_WRITE : LOP_READ;
      held_addr  <= addr;
      held_wdata <= wr_stb ? wdata : '0;
    end
  end

endmodule

// File: rtl/cfgarb_sched.sv
module cfgarb_sched
  import cfgarb_pkg::*;
#(
  parameter int DATA_W = CFG_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pri_req,
  input  logic              held_vld,
  input  lop_e              held_op,
  input  logic              held_inr,
  input  logic [DATA_W-1:0] rd_word,
  output logic              loc_go,
  output logic              loc_ack,
  output logic [DATA_W-1:0] loc_rdata
);

  // The primary port owns the access path whenever it asks for it.
  assign loc_go = held_vld && !pri_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      loc_ack   <= 1'b0;
      loc_rdata <= '0;
    end else begin
      loc_ack <= loc_go;
      if (loc_go) begin
        loc_rdata <= (held_op == LOP_READ && held_inr) ? rd_word : '0;
      end
    end
  end

endmodule

// File: rtl/cfgarb_store.sv
module cfgarb_store #(
  parameter int              DATA_W    = 32,
  parameter int              WORDS     = 128,
  parameter int              RO_WORDS  = 4,
  parameter logic [DATA_W-1:0] EVEN_MASK = 32'hFFFF_00FF,
  parameter logic [DATA_W-1:0] ODD_MASK  = 32'h0F0F_FFFF,
  parameter logic [DATA_W-1:0] RST_BASE  = 32'hA5C3_0000,
  localparam int             IDX_W     = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_word
);

  logic [DATA_W-1:0] word_bus [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam logic [DATA_W-1:0] WMASK =
      (w < RO_WORDS) ? '0 : ((w % 2 == 1) ? ODD_MASK : EVEN_MASK);
    localparam logic [DATA_W-1:0] WRST = RST_BASE ^ DATA_W'(w);

    logic [DATA_W-1:0] q;

    always_ff @(posedge clk) begin
      if (rst) begin
        q <= WRST;
      end else if (wr_en && wr_idx == IDX_W'(w)) begin
        q <= (q & ~WMASK) | (wr_data & WMASK);
      end
    end

    assign word_bus[w] = q;
  end

  assign rd_word = word_bus[rd_idx];

endmodule

// File: rtl/cfgarb_top.sv
module cfgarb_top
  import cfgarb_pkg::*;
#(
  parameter int              ADDR_W    = CFG_ADDR_W,
  parameter int              DATA_W    = CFG_DATA_W,
  parameter int              WORDS     = 128,
  parameter int              RO_WORDS  = 4,
  parameter logic [DATA_W-1:0] EVEN_MASK = 32'hFFFF_00FF,
  parameter logic [DATA_W-1:0] ODD_MASK  = 32'h0F0F_FFFF,
  parameter logic [DATA_W-1:0] RST_BASE  = 32'hA5C3_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pri_req,
  input  logic              pri_we,
  input  logic [ADDR_W-1:0] pri_addr,
  input  logic [DATA_W-1:0] pri_wdata,
  output logic              pri_rvalid,
  output logic [DATA_W-1:0] pri_rdata,
  input  logic              loc_rden,
  input  logic              loc_wren,
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic [DATA_W-1:0] loc_wdata,
  output logic [DATA_W-1:0] loc_rdata,
  output logic              loc_ack
);

  localparam int IDX_W = $clog2(WORDS);
  localparam int LSB   = $clog2(DATA_W / 8);
  localparam int MAP_W = IDX_W + LSB;

  logic              held_vld;
  lop_e              held_op;
  logic [ADDR_W-1:0] held_addr;
  logic [DATA_W-1:0] held_wdata;
  logic              loc_go;

  logic              pri_inr, held_inr;
  logic [IDX_W-1:0]  pri_idx, held_idx;
  logic              acc_wr;
  logic [IDX_W-1:0]  acc_idx;
  logic [DATA_W-1:0] acc_wdata;
  logic [DATA_W-1:0] rd_word;

  wire unused_addr_bits = ^{pri_addr[LSB-1:0], held_addr[LSB-1:0]};

  assign pri_inr  = (pri_addr  >> MAP_W) == '0;
  assign held_inr = (held_addr >> MAP_W) == '0;
  assign pri_idx  = pri_addr[MAP_W-1:LSB];
  assign held_idx = held_addr[MAP_W-1:LSB];

  cfgarb_hold #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_hold (
    .clk        (clk),
    .rst        (rst),
    .rd_stb     (loc_rden),
    .wr_stb     (loc_wren),
    .addr       (loc_addr),
    .wdata      (loc_wdata),
    .done       (loc_go),
    .held_vld   (held_vld),
    .held_op    (held_op),
    .held_addr  (held_addr),
    .held_wdata (held_wdata)
  );

  cfgarb_sched #(
    .DATA_W (DATA_W)
  ) u_sched (
    .clk       (clk),
    .rst       (rst),
    .pri_req   (pri_req),
    .held_vld  (held_vld),
    .held_op   (held_op),
    .held_inr  (held_inr),
    .rd_word   (rd_word),
    .loc_go    (loc_go),
    .loc_ack   (loc_ack),
    .loc_rdata (loc_rdata)
  );

  // Single shared access path: primary first, else the held local request.
  always_comb begin
    if (pri_req) begin
      acc_idx   = pri_idx;
      acc_wdata = pri_wdata;
      acc_wr    = pri_we && pri_inr;
    end else begin
      acc_idx   = held_idx;
      acc_wdata = held_wdata;
      acc_wr    = loc_go && held_op == LOP_WRITE && held_inr;
    end
  end

  cfgarb_store #(
    .DATA_W    (DATA_W),
    .WORDS     (WORDS),
    .RO_WORDS  (RO_WORDS),
    .EVEN_MASK (EVEN_MASK),
    .ODD_MASK  (ODD_MASK),
    .RST_BASE  (RST_BASE)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (acc_wr),
    .wr_idx  (acc_idx),
    .wr_data (acc_wdata),
    .rd_idx  (acc_idx),
    .rd_word (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pri_rvalid <= 1'b0;
      pri_rdata  <= '0;
    end else begin
      pri_rvalid <= pri_req && !pri_we;
      if (pri_req && !pri_we) begin
        pri_rdata <= pri_inr ? rd_word : '0;
      end
    end
  end

endmodule

// File: rtl/cfgarb_chk.sv
module cfgarb_chk (
  input logic clk,
  input logic rst,
  input logic pri_req,
  input logic pri_we,
  input logic loc_ack,
  input logic pri_rvalid,
  input logic held_vld,
  input logic loc_go
);

  p_no_ack_in_reset_r1: assert property (@(posedge clk)
    rst |=> !loc_ack && !pri_rvalid);

  p_pri_blocks_local_r5: assert property (@(posedge clk) disable iff (rst)
    pri_req |=> !loc_ack);

  p_held_survives_pri_r5: assert property (@(posedge clk) disable iff (rst)
    held_vld && pri_req |=> held_vld);

  p_ack_single_r6: assert property (@(posedge clk) disable iff (rst)
    loc_ack |=> !loc_ack);

  p_ack_from_held_r7: assert property (@(posedge clk) disable iff (rst)
    loc_ack |-> $past(held_vld));

  p_go_clears_slot_r7: assert property (@(posedge clk) disable iff (rst)
    loc_go |=> !held_vld);

  p_pri_read_valid_r9: assert property (@(posedge clk) disable iff (rst)
    pri_req && !pri_we |=> pri_rvalid);

  p_no_spurious_rvalid_r9: assert property (@(posedge clk) disable iff (rst)
    !(pri_req && !pri_we) |=> !pri_rvalid);

endmodule

bind cfgarb_top cfgarb_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .pri_req    (pri_req),
  .pri_we     (pri_we),
  .loc_ack    (loc_ack),
  .pri_rvalid (pri_rvalid),
  .held_vld   (held_vld),
  .loc_go     (loc_go)
);

// File: tb/cfgarb_top_tb.sv
module cfgarb_top_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        pri_req, pri_we;
  logic [11:0] pri_addr;
  logic [31:0] pri_wdata;
  logic        pri_rvalid;
  logic [31:0] pri_rdata;
  logic        loc_rden, loc_wren;
  logic [11:0] loc_addr;
  logic [31:0] loc_wdata;
  logic [31:0] loc_rdata;
  logic        loc_ack;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] mdl [128];

  always #2 clk = ~clk;

  cfgarb_top u_dut (
    .clk(clk), .rst(rst),
    .pri_req(pri_req), .pri_we(pri_we), .pri_addr(pri_addr), .pri_wdata(pri_wdata),
    .pri_rvalid(pri_rvalid), .pri_rdata(pri_rdata),
    .loc_rden(loc_rden), .loc_wren(loc_wren), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
    .loc_rdata(loc_rdata), .loc_ack(loc_ack)
  );

  function automatic logic [31:0] mask_of(int i);
    if (i < 4) return 32'h0;
    return (i % 2 == 1) ? 32'h0F0F_FFFF : 32'hFFFF_00FF;
  endfunction

  function automatic logic [31:0] rst_of(int i);
    return 32'hA5C3_0000 ^ 32'(i);
  endfunction

  function automatic bit in_rng(logic [11:0] a);
    return a[11:9] == 3'b000;
  endfunction

  function automatic logic [31:0] mread(logic [11:0] a);
    return in_rng(a) ? mdl[a[8:2]] : 32'h0;
  endfunction

  task automatic mwrite(logic [11:0] a, logic [31:0] d);
    logic [31:0] m;
    if (in_rng(a)) begin
      m = mask_of(int'(a[8:2]));
      mdl[a[8:2]] = (mdl[a[8:2]] & ~m) | (d & m);
    end
  endtask

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] rand_addr();
    logic [11:0] a;
    a = 12'($urandom);
    if ($urandom % 8 != 0) a[11:9] = 3'b000;
    return a;
  endfunction

  task automatic idle_inputs();
    pri_req = 0; pri_we = 0; pri_addr = '0; pri_wdata = '0;
    loc_rden = 0; loc_wren = 0; loc_addr = '0; loc_wdata = '0;
  endtask

  task automatic pri_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    pri_req = 1; pri_we = 1; pri_addr = a; pri_wdata = d;
    mwrite(a, d);
    @(negedge clk);
    pri_req = 0; pri_we = 0;
  endtask

  task automatic pri_read_chk(logic [11:0] a, string tag);
    logic [31:0] e;
    e = mread(a);
    @(negedge clk);
    pri_req = 1; pri_we = 0; pri_addr = a;
    @(negedge clk);
    chk(pri_rvalid === 1'b1, "R9 rvalid", 32'(pri_rvalid), 32'd1);
    chk(pri_rdata === e, tag, pri_rdata, e);
    pri_req = 0;
  endtask

  // Local access with k cycles of primary traffic starting in the strobe cycle
  // and optional junk strobes while the request is held.
  task automatic loc_op(bit rd, bit wr, logic [11:0] a, logic [31:0] d, int k, bit junk);
    bit          prd_pend = 0;
    logic [31:0] prd_exp = '0;
    int          lat = -1;
    int          want;
    logic [31:0] e;
    want = ((k > 1) ? k : 1) + 1;
    @(negedge clk);
    loc_rden = rd; loc_wren = wr; loc_addr = a; loc_wdata = d;
    if (k > 0) begin
      pri_req = 1; pri_we = ($urandom % 3 == 0); pri_addr = rand_addr(); pri_wdata = $urandom;
      if (pri_we) mwrite(pri_addr, pri_wdata);
      else begin prd_pend = 1; prd_exp = mread(pri_addr); end
    end
    for (int j = 1; j <= 40; j++) begin
      @(negedge clk);
      if (prd_pend) begin
        chk(pri_rvalid === 1'b1 && pri_rdata === prd_exp, "R9 pri read during hold",
            pri_rdata, prd_exp);
        prd_pend = 0;
      end
      if (loc_ack === 1'b1) begin
        lat = j;
        break;
      end
      loc_rden = 0; loc_wren = 0;
      if (junk) begin
        loc_rden = $urandom % 2; loc_wren = $urandom % 2;
        loc_addr = rand_addr(); loc_wdata = $urandom;
      end
      pri_req = 0; pri_we = 0;
      if (j < k) begin
        pri_req = 1; pri_we = ($urandom % 3 == 0); pri_addr = rand_addr(); pri_wdata = $urandom;
        if (pri_we) mwrite(pri_addr, pri_wdata);
        else begin prd_pend = 1; prd_exp = mread(pri_addr); end
      end
    end
    idle_inputs();
    chk(lat == want, "R5 ack latency", 32'(lat), 32'(want));
    e = wr ? 32'h0 : mread(a);
    chk(loc_rdata === e, wr ? "R8 write rdata zero" : "R6 local read data", loc_rdata, e);
    if (wr) mwrite(a, d);
    @(negedge clk);
    chk(loc_ack === 1'b0, "R6 ack one cycle", 32'(loc_ack), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle_inputs();
    rst = 1;
    for (int i = 0; i < 128; i++) mdl[i] = rst_of(i);
    repeat (3) @(negedge clk);
    chk(loc_ack === 1'b0 && pri_rvalid === 1'b0, "R1 outputs in reset",
        {30'd0, loc_ack, pri_rvalid}, 32'd0);
    rst = 0;
    @(negedge clk);
    chk(loc_ack === 1'b0 && pri_rvalid === 1'b0, "R1 outputs after reset",
        {30'd0, loc_ack, pri_rvalid}, 32'd0);
    pri_read_chk(12'h000, "R1 reset word0");
    pri_read_chk(12'h1FC, "R1 reset word127");
    loc_op(1, 0, 12'h014, 0, 0, 0);

    // R4 read-only header and masks, from the primary port
    pri_write(12'h008, 32'hFFFF_FFFF);
    pri_read_chk(12'h008, "R4 read-only word via primary");
    pri_write(12'h014, 32'h1234_5678);
    pri_read_chk(12'h014, "R4 odd mask via primary");
    loc_op(0, 1, 12'h018, 32'hDEAD_BEEF, 0, 0);
    pri_read_chk(12'h018, "R4 even mask via local");
    loc_op(0, 1, 12'h00C, 32'h0, 0, 0);
    pri_read_chk(12'h00C, "R4 read-only word via local");

    // R2 low address bits ignored
    loc_op(0, 1, 12'h023, 32'hCAFE_F00D, 0, 0);
    pri_read_chk(12'h020, "R2 aligned alias");
    pri_read_chk(12'h021, "R2 unaligned primary");

    // R3 out of range
    loc_op(0, 1, 12'hA14, 32'hFFFF_FFFF, 2, 0);
    pri_read_chk(12'h014, "R3 dropped write");
    loc_op(1, 0, 12'hA14, 0, 0, 0);
    pri_read_chk(12'hE00, "R3 primary read zero");

    // R8 both strobes
    loc_op(1, 1, 12'h030, 32'h5555_AAAA, 0, 0);
    pri_read_chk(12'h030, "R8 both strobes wrote");

    // R5 and R7 directed priority and junk
    loc_op(1, 0, 12'h030, 0, 5, 1);
    loc_op(0, 1, 12'h034, 32'h0F0F_0F0F, 6, 1);
    pri_read_chk(12'h034, "R7 junk did not land");

    for (int n = 0; n < 400; n++) begin
      bit rd, wr;
      wr = $urandom % 2;
      rd = wr ? ($urandom % 2) : 1'b1;
      loc_op(rd, wr, rand_addr(), $urandom, $urandom % 7, $urandom % 2);
      if (n % 16 == 0) pri_read_chk(rand_addr(), "R4 random readback");
    end
    for (int i = 0; i < 128; i++) pri_read_chk(12'(i * 4), "R4 final sweep");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule